// File: doc/BRIEF.md
# Byte SPI Master with Register Interface

This block is a single-byte SPI master attached to a narrow microcontroller-style register bus. Software programs a control register, then writes a byte to the data register. The block then runs eight full SCK periods and shifts the byte out on MOSI, most significant bit first. At the same time it assembles a byte from MISO samples. SCK speed, idle level and sampling phase all come from the control register.

When the last bit completes, a completion flag rises, and this flag can drive an interrupt line. A data write that arrives while a byte is still moving does not restart the shift. It raises a collision flag instead. Flags are cleared only by a two-step handshake: a status read, then an access to the data register. That access clears exactly the flags the status read observed.

The bus has separate single-cycle read and write strobes and a 2-bit address. Read data is combinational on the address. A read has side effects only when the read strobe is high.

Top module: `spi_master_ctl`

## Requirements
- R1: After a synchronous active-low reset, control (address 0) reads 0x00, status (address 1) reads 0x00, SCK is low and the interrupt output is low.
- R2: Control bits [1:0] select the SCK half-period as RATE_SCALE times 1, 2, 8 or 16 clocks, for field values 0 to 3. The completion flag therefore becomes visible 16×half-period clock edges after the edge that accepted the data write.
- R3: A transfer sends the written byte on MOSI from bit 7 down to bit 0. It assembles eight MISO samples, with the first sample landing in bit 7. After completion, a data-register (address 2) read returns that assembled byte.
- R4: SCK rests at the level of control bit 3 whenever no transfer runs. A transfer produces exactly 16 SCK transitions and ends at that rest level.
- R5: With control bit 2 clear, MOSI presents bit 7 before the first SCK transition, MISO is captured on odd-numbered transitions and MOSI changes on even ones. With the bit set, MOSI changes on odd transitions after the first, and MISO is captured on even transitions.
- R6: A data write while control bit 6 (enable) is clear has no effect: no SCK activity, no flag change, and the data register keeps its old received byte.
- R7: A data write during a transfer sets status bit 6 (collision) and leaves the running transfer and its transmitted byte unchanged.
- R8: Status bit 7 (complete) sets when the last bit finishes. The interrupt output is high exactly while status bit 7 and control bit 7 are both 1.
- R9: Flags clear only when a status read that saw them set is followed by a data read, or by an enabled data write. A data access with no prior status read leaves them set.
- R10: The data access in the clear sequence clears only those flags that were set at the preceding status read.
- R11: Bus writes to the status register have no effect on it.
- R12: Reset aborts a running transfer (SCK back to rest, no completion flag), clears control, and cancels a pending clear sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (enables read side effects) |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default RATE_SCALE of 1. At that setting a half-period is 1, 2, 8 or 16 clocks, so the bench can run every rate setting and measure the exact completion cycle in a short run. A behavioural slave follows each of the four polarity and phase combinations and checks the MOSI bit order against the assembled byte. With a 2-clock half-period, the bench has enough time to land a collision write and a status read inside one transfer. The directed scenarios also cover partial flag clears, writes to the read-only status register, and a reset in the middle of a transfer.

// File: rtl/spi_mc_pkg.sv
// Package: register map and control-field layout shared by the SPI master.
// Assumes 8-bit registers on a 2-bit address bus.
package spi_mc_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

    // Control register, MSB first: irq enable, enable, wired-or option,
    // master select, polarity, phase, rate field.
    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       wor_opt;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam int STAT_DONE_BIT = 7;
    localparam int STAT_COLL_BIT = 6;
endpackage

// File: rtl/spi_mc_clkdiv.sv
// Module: half-period tick generator for SCK.
// Produces one tick every RATE_SCALE*{1,2,8,16} clocks while run is high;
// restarts its count whenever run is low. Assumes rate is stable during a run.
module spi_mc_clkdiv #(
    parameter int RATE_SCALE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int MAX_HALF = 16 * RATE_SCALE;
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_len;

    // Decode the rate field into a half-period length in clocks.
    always_comb begin
        case (rate)
            2'd0:    half_len = CNT_W'(RATE_SCALE);
            2'd1:    half_len = CNT_W'(2 * RATE_SCALE);
            2'd2:    half_len = CNT_W'(8 * RATE_SCALE);
            default: half_len = CNT_W'(16 * RATE_SCALE);
        endcase
    end

    assign tick = run && (cnt == half_len - 1'b1);

    // Count clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // Ticks are never back to back when the half-period exceeds one clock.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (half_len > CNT_W'(1))) |=> !tick);
endmodule

// File: rtl/spi_mc_shifter.sv
// Module: byte shift engine for the SPI master.
// On start it loads the byte and then, on each half-period tick, toggles the
// SCK phase, captures MISO or advances MOSI according to cpha, and stops after
// 2*DATA_W ticks. Assumes start only arrives while idle.
module spi_mc_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              cpha,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              phase,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    logic [EW-1:0]     edge_cnt;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic              lead;
    logic              last;
    logic              sample;
    logic              advance;

    assign lead    = ~edge_cnt[0];
    assign last    = (edge_cnt == EW'(EDGES - 1));
    assign sample  = tick & (cpha ? ~lead : lead);
    assign advance = tick & ~last & (cpha ? (lead & (edge_cnt != '0)) : ~lead);
    assign done    = tick & last;
    assign mosi    = tx_sh[DATA_W-1];
    assign rx_next = sample ? {rx_sh[DATA_W-2:0], miso} : rx_sh;

    // Load on start, then step one SCK half-period per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            phase    <= 1'b0;
            edge_cnt <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            phase    <= 1'b0;
            edge_cnt <= '0;
            tx_sh    <= tx_byte;
            rx_sh    <= '0;
        end else if (busy && tick) begin
            phase    <= ~phase;
            edge_cnt <= edge_cnt + 1'b1;
            rx_sh    <= rx_next;
            if (advance) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            if (last) begin
                busy    <= 1'b0;
                rx_byte <= rx_next;
            end
        end
    end

    // The final tick ends the transfer.
    assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // SCK phase is back at rest whenever a transfer ends.
    assert_sck_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !phase);
endmodule

// File: rtl/spi_master_ctl.sv
// Module: register-mapped SPI master (top).
// Holds control, status flags and the status-then-data clear sequence, and
// drives the divider and shift engine. Assumes single-cycle bus strobes;
// rdata is combinational on addr.
module spi_master_ctl
    import spi_mc_pkg::*;
#(
    parameter int RATE_SCALE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    ctrl_t            ctrl;
    logic             spif;
    logic             wcol;
    logic [1:0]       seen;
    logic [1:0]       clr;
    logic             busy;
    logic             done;
    logic             phase;
    logic             tick;
    logic             dat_wr;
    logic             dat_rd;
    logic             st_rd;
    logic             start;
    logic             collide;
    logic [REG_W-1:0] rx_byte;

    assign dat_wr  = wr_en && (addr == ADDR_DATA) && ctrl.enable;
    assign dat_rd  = rd_en && (addr == ADDR_DATA);
    assign st_rd   = rd_en && (addr == ADDR_STAT);
    assign start   = dat_wr && !busy;
    assign collide = dat_wr && busy;
    assign clr     = (dat_wr || dat_rd) ? seen : 2'b00;

    // Control register: plain read/write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl <= '0;
        else if (wr_en && addr == ADDR_CTRL)    ctrl <= ctrl_t'(wdata);
    end

    // Remember which flags a status read observed, until the data access.
    always_ff @(posedge clk) begin
        if (!rst_n)                  seen <= 2'b00;
        else if (st_rd)              seen <= {spif, wcol};
        else if (dat_wr || dat_rd)   seen <= 2'b00;
    end

    // Completion and collision flags: set by events, cleared by the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spif <= 1'b0;
            wcol <= 1'b0;
        end else begin
            spif <= (spif & ~clr[1]) | done;
            wcol <= (wcol & ~clr[0]) | collide;
        end
    end

    // Register read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: rdata = ctrl;
            ADDR_STAT: begin
                rdata[STAT_DONE_BIT] = spif;
                rdata[STAT_COLL_BIT] = wcol;
            end
            ADDR_DATA: rdata = rx_byte;
            default:   rdata = '0;
        endcase
    end

    assign irq = ctrl.irq_en & spif;
    assign sck = ctrl.cpol ^ phase;

    spi_mc_clkdiv #(
        .RATE_SCALE(RATE_SCALE)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .rate (ctrl.rate),
        .tick (tick)
    );

    spi_mc_shifter #(
        .DATA_W(REG_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tx_byte(wdata),
        .cpha   (ctrl.cpha),
        .tick   (tick),
        .miso   (miso),
        .busy   (busy),
        .done   (done),
        .phase  (phase),
        .mosi   (mosi),
        .rx_byte(rx_byte)
    );

    // SCK rests at the polarity level outside transfers.
    assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == ctrl.cpol));
    // Completion only follows a running transfer.
    assert_done_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spif) |-> $past(busy));
    // A collision only comes from a write during a transfer.
    assert_coll_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(busy));
    // Status writes never raise a flag on their own.
    assert_stat_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STAT && !busy && !spif) |=> !spif);
endmodule

// File: tb/tb_spi_master_ctl.sv
module tb_spi_master_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    wire  [7:0] rdata;
    wire        sck;
    wire        mosi;
    wire        miso;
    wire        irq;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Behavioural slave: tracks SCK transitions, captures MOSI, shifts MISO.
    logic [7:0] s_reg = 8'h00;
    logic [7:0] m_cap = 8'h00;
    int         k = 0;
    bit         on = 1'b0;
    bit         s_cpha = 1'b0;
    assign miso = s_reg[7];

    always #10 clk = ~clk;

    spi_master_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
        .irq(irq)
    );

    always @(sck) begin
        if (on) begin
            k = k + 1;
            if (s_cpha ? (k % 2 == 0) : (k % 2 == 1)) m_cap = {m_cap[6:0], mosi};
            if (s_cpha ? (k % 2 == 1 && k > 1) : (k % 2 == 0 && k < 16))
                s_reg = {s_reg[6:0], 1'b0};
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(output int n);
        logic [7:0] v;
        n = 1;
        peek(A_STAT, v);
        while (!v[7] && n < 2000) begin
            @(negedge clk);
            peek(A_STAT, v);
            n++;
        end
    endtask

    task automatic clear_flags();
        logic [7:0] v;
        bus_rd(A_STAT, v);
        bus_rd(A_DATA, v);
    endtask

    // One transfer with the slave model; optionally runs the clear sequence.
    task automatic xfer(input logic [7:0] cv, input logic [7:0] tx,
                        input logic [7:0] sl, input bit clr, output int n);
        logic [7:0] v;
        bus_wr(A_CTRL, cv);
        chk(sck == cv[3], "R4 rest level before start", sck, cv[3]);
        s_reg = sl; m_cap = 8'h00; k = 0; s_cpha = cv[2]; on = 1'b1;
        bus_wr(A_DATA, tx);
        chk(mosi == tx[7], "R5 MOSI bit7 before first edge", mosi, tx[7]);
        wait_done(n);
        on = 1'b0;
        chk(k == 16, "R4 SCK transitions", k, 16);
        chk(m_cap == tx, "R3 MOSI byte MSB first", m_cap, tx);
        chk(sck == cv[3], "R4 rest level after end", sck, cv[3]);
        if (clr) begin
            bus_rd(A_STAT, v);
            bus_rd(A_DATA, v);
            chk(v == sl, "R3/R5 received byte", v, sl);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(A_CTRL, v); chk(v == 8'h00, "R1 control", v, 0);
        peek(A_STAT, v); chk(v == 8'h00, "R1 status", v, 0);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_modes();
        int n;
        for (int m = 0; m < 4; m++) begin
            xfer(8'h40 | 8'(m << 2), 8'h96 ^ 8'(m * 17), 8'h4B + 8'(m * 33), 1'b1, n);
        end
    endtask

    task automatic t_rates();
        int n;
        int h;
        for (int r = 0; r < 4; r++) begin
            h = (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 8 : 16;
            xfer(8'h40 | 8'(r), 8'hC3, 8'h5A, 1'b1, n);
            chk(n == 16 * h + 1, "R2 completion cycle", n, 16 * h + 1);
        end
    endtask

    task automatic t_spe_off();
        logic [7:0] old;
        logic [7:0] v;
        bus_wr(A_CTRL, 8'h00);
        bus_rd(A_DATA, old);
        k = 0; on = 1'b1;
        bus_wr(A_DATA, 8'hE7);
        repeat (40) @(negedge clk);
        on = 1'b0;
        chk(k == 0, "R6 no SCK when disabled", k, 0);
        peek(A_STAT, v); chk(v == 8'h00, "R6 no flags", v, 0);
        bus_rd(A_DATA, v); chk(v == old, "R6 data unchanged", v, old);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        int n;
        bus_wr(A_CTRL, 8'h41);
        s_reg = 8'h00; m_cap = 8'h00; k = 0; s_cpha = 1'b0; on = 1'b1;
        bus_wr(A_DATA, 8'hA5);
        repeat (4) @(negedge clk);
        bus_wr(A_DATA, 8'h3C);
        bus_rd(A_STAT, v); chk(v == 8'h40, "R7 collision flag", v, 8'h40);
        wait_done(n);
        on = 1'b0;
        chk(m_cap == 8'hA5, "R7 transfer undisturbed", m_cap, 8'hA5);
        chk(k == 16, "R7 transfer length", k, 16);
        bus_rd(A_DATA, v);
        peek(A_STAT, v); chk(v == 8'h80, "R10 only seen flag cleared", v, 8'h80);
        clear_flags();
        peek(A_STAT, v); chk(v == 8'h00, "R9 full clear", v, 0);
    endtask

    task automatic t_irq();
        int n;
        xfer(8'hC0, 8'h11, 8'h22, 1'b0, n);
        chk(irq == 1'b1, "R8 irq with enable", irq, 1);
        bus_wr(A_CTRL, 8'h40);
        chk(irq == 1'b0, "R8 irq masked", irq, 0);
        bus_wr(A_CTRL, 8'hC0);
        chk(irq == 1'b1, "R8 irq re-enabled", irq, 1);
        clear_flags();
        chk(irq == 1'b0, "R8 irq after clear", irq, 0);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        int n;
        xfer(8'h40, 8'h0F, 8'hF0, 1'b0, n);
        bus_rd(A_DATA, v);
        peek(A_STAT, v); chk(v == 8'h80, "R9 no clear without status read", v, 8'h80);
        bus_rd(A_STAT, v);
        bus_wr(A_DATA, 8'h5A);
        peek(A_STAT, v); chk(v[7] == 1'b0, "R9 clear by data write", v, 0);
        wait_done(n);
        clear_flags();
    endtask

    task automatic t_status_ro();
        logic [7:0] v;
        int n;
        bus_wr(A_STAT, 8'hFF);
        peek(A_STAT, v); chk(v == 8'h00, "R11 write ones", v, 0);
        xfer(8'h40, 8'h77, 8'h88, 1'b0, n);
        bus_wr(A_STAT, 8'h00);
        peek(A_STAT, v); chk(v == 8'h80, "R11 write zeros", v, 8'h80);
        clear_flags();
    endtask

    task automatic t_reset_mid();
        logic [7:0] v;
        int n;
        bus_wr(A_CTRL, 8'h4E);
        bus_wr(A_DATA, 8'h81);
        repeat (20) @(negedge clk);
        pulse_reset();
        k = 0; on = 1'b1;
        repeat (300) @(negedge clk);
        on = 1'b0;
        chk(k == 0, "R12 transfer aborted", k, 0);
        chk(sck == 1'b0, "R12 sck at rest", sck, 0);
        peek(A_CTRL, v); chk(v == 8'h00, "R12 control cleared", v, 0);
        peek(A_STAT, v); chk(v == 8'h00, "R12 no completion", v, 0);
        xfer(8'h40, 8'h12, 8'h34, 1'b0, n);
        bus_rd(A_STAT, v);
        pulse_reset();
        xfer(8'h40, 8'h56, 8'h78, 1'b0, n);
        bus_rd(A_DATA, v);
        peek(A_STAT, v); chk(v == 8'h80, "R12 pending clear cancelled", v, 8'h80);
        clear_flags();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_rates();
        t_spe_off();
        t_collision();
        t_irq();
        t_clear();
        t_status_ro();
        t_reset_mid();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule